// File: doc/BRIEF.md
# Page access permission and fault code checker

This block takes the permission bits that a page walk has already merged across its levels. It also takes the processor control state that governs access rights. From these it decides whether one memory access may proceed. It applies four rules to reach its verdict: the user/supervisor split, supervisor write protection, no-execute together with the supervisor-execute guard, and per-key access rights. It reports the set of operations the page permits (read, write, execute). When the access is refused, it also reports the page-fault error code that the fault handler will receive.

Each check travels as one request on a valid/ready stream, and each request yields one result on an output stream. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. With the default `REG_OUT = 1`, the result sits in a single register stage. The input side then accepts a request whenever that stage is empty or is being drained in the same cycle. While the consumer holds `out_ready` low, a pending result stays unchanged and new requests are held off. With `REG_OUT = 0`, the block is a purely combinational path, and the ready and valid signals pass straight through.

Top module: `pgchk_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: A request with `pg_present` = 0 is refused with `out_perm` = 0. In its error code, bit 0 and bit 3 are clear and bit 5 is clear. Bits 1, 2 and 4 still describe the access.
- R3: A present request with `pg_rsvd_hit` = 1 is refused with `out_perm` = 0, and error code bits 0 and 3 are both set.
- R4: A user access (`acc_user` = 1) to a page whose user bit is clear is refused with `out_perm` = 0. Error code bits 0 and 2 are set and bit 5 is clear.
- R5: Write is in the base permitted set (`out_perm` bit 1) when `pg_rw` = 1, or when the access is supervisor and `sup_wp` = 0. Read (`out_perm` bit 0) is always in the base set.
- R6: Execute (`out_perm` bit 2) is permitted when `pg_nx` = 0 and either the access is user, or it is not the case that `exec_guard` = 1 on a user page.
- R7: Key rights take effect only when all four of the following hold: `key_en` = 1, `long_mode` = 1, the page user bit is set, and `key_rights` is nonzero. Otherwise they change nothing.
- R8: Key k owns `key_rights` bit 2k (access disable) and bit 2k+1 (write disable). Access disable removes read and write. Write disable removes write, but only for user accesses or for supervisor accesses with `sup_wp` = 1. Execute is never removed by a key.
- R9: When a read or write is refused because of key rights, error code bit 5 is set together with bit 0. This holds even if the base write rule would also refuse it.
- R10: In the error code of a refused access, bit 1 is 1 for `acc_type` = 1 (write) and bit 2 equals `acc_user`. Bit 4 is 1 for `acc_type` = 2 (fetch) when either `noexec_en` and `wide_entry` are both 1, or `exec_guard` = 1.
- R11: `acc_type` encodes the access as 0 read, 1 write, 2 fetch, with 3 handled as a read. `out_allow` is 1 exactly when the matching `out_perm` bit is 1, and an allowed access has `out_err` = 0.
- R12: With `REG_OUT` = 1, each accepted request yields one result one cycle later, in order. `in_ready` = !`out_valid` || `out_ready`. A result held with `out_ready` = 0 keeps all its fields stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with `in_valid` |
| pg_user | input | 1 | Merged user bit of the walk |
| pg_rw | input | 1 | Merged writable bit of the walk |
| pg_nx | input | 1 | Merged no-execute bit of the walk |
| pg_present | input | 1 | Translation reached a present final entry |
| pg_rsvd_hit | input | 1 | Walk found a reserved bit set |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| acc_user | input | 1 | Access made at user privilege |
| sup_wp | input | 1 | Supervisor writes honour read-only pages |
| exec_guard | input | 1 | Supervisor may not execute user pages |
| noexec_en | input | 1 | No-execute feature enabled |
| wide_entry | input | 1 | Wide (64-bit) table entries in use |
| key_en | input | 1 | Protection keys enabled |
| long_mode | input | 1 | Long mode active |
| pg_key | input | KEY_W | Protection key of the page |
| key_rights | input | RIGHTS_W | Two rights bits per key |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_allow | output | 1 | Access may proceed |
| out_perm | output | 3 | Permitted set: bit 0 read, bit 1 write, bit 2 execute |
| out_err | output | 6 | Page-fault error code, 0 when allowed |

## Verification
The hardest situation to reach is a refusal caused by the key rights alone. It needs key enable, long mode, a user page, nonzero rights and the correct bit pair for the chosen key, all at once, with the base rules still allowing the access. Uniform random draws almost never line these up. The stimulus therefore forces key enable, long mode and the user bit high in a large share of requests. It sets the rights of the drawn key directly, and it adds directed requests at key 0 and at the top key. Random consumer stalls keep results waiting, so that ordering and holding are exercised alongside.

// File: rtl/pgchk_pkg.sv
package pgchk_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  localparam int PERM_W = 3;
  localparam int ERR_W  = 6;

  localparam int EB_PROT  = 0;
  localparam int EB_WRITE = 1;
  localparam int EB_USER  = 2;
  localparam int EB_RSVD  = 3;
  localparam int EB_FETCH = 4;
  localparam int EB_KEY   = 5;

  typedef struct packed {
    logic exec;
    logic write;
    logic read;
  } perm_t;

endpackage

// File: rtl/pgchk_base_perm.sv
module pgchk_base_perm
  import pgchk_pkg::*;
(
  input  logic  pg_user,
  input  logic  pg_rw,
  input  logic  pg_nx,
  input  logic  acc_user,
  input  logic  sup_wp,
  input  logic  exec_guard,
  output perm_t base,
  output logic  user_fault
);

  always_comb begin
    user_fault = acc_user & ~pg_user;
    base.read  = 1'b1;
    base.write = pg_rw | (~acc_user & ~sup_wp);
    base.exec  = ~pg_nx & (acc_user | ~(exec_guard & pg_user));
  end

endmodule

// File: rtl/pgchk_key_perm.sv
module pgchk_key_perm
  import pgchk_pkg::*;
#(
  parameter int KEY_W    = 4,
  parameter int RIGHTS_W = 2 * (1 << KEY_W)
) (
  input  logic                key_en,
  input  logic                long_mode,
  input  logic                pg_user,
  input  logic                acc_user,
  input  logic                sup_wp,
  input  logic [KEY_W-1:0]    pg_key,
  input  logic [RIGHTS_W-1:0] key_rights,
  output logic                key_active,
  output perm_t               mask
);

  localparam int IDX_W = KEY_W + 1;

  logic [IDX_W-1:0] ad_idx;
  logic [IDX_W-1:0] wd_idx;
  logic             acc_dis;
  logic             wr_dis;

  always_comb begin
    ad_idx     = {pg_key, 1'b0};
    wd_idx     = {pg_key, 1'b1};
    acc_dis    = key_rights[ad_idx];
    wr_dis     = key_rights[wd_idx];
    key_active = key_en & long_mode & pg_user & (|key_rights);
    mask       = '{exec: 1'b1, write: 1'b1, read: 1'b1};
    if (key_active) begin
      if (acc_dis) begin
        mask.read  = 1'b0;
        mask.write = 1'b0;
      end else if (wr_dis && (acc_user || sup_wp)) begin
        mask.write = 1'b0;
      end
    end
  end

endmodule

// File: rtl/pgchk_errcode.sv
module pgchk_errcode
  import pgchk_pkg::*;
(
  input  logic             allow,
  input  logic             present,
  input  logic             rsvd_hit,
  input  logic             user_fault,
  input  logic             key_fault,
  input  acc_e             acc,
  input  logic             acc_user,
  input  logic             noexec_en,
  input  logic             wide_entry,
  input  logic             exec_guard,
  output logic [ERR_W-1:0] err
);

  always_comb begin
    err = '0;
    if (!allow) begin
      err[EB_PROT]  = present;
      err[EB_WRITE] = (acc == ACC_WRITE);
      err[EB_USER]  = acc_user;
      err[EB_RSVD]  = present & rsvd_hit;
      err[EB_FETCH] = (acc == ACC_FETCH) & ((noexec_en & wide_entry) | exec_guard);
      err[EB_KEY]   = present & ~rsvd_hit & ~user_fault & key_fault;
    end
  end

endmodule

// File: rtl/pgchk_top.sv
module pgchk_top
  import pgchk_pkg::*;
#(
  parameter int KEY_W    = 4,
  parameter int RIGHTS_W = 2 * (1 << KEY_W),
  parameter bit REG_OUT  = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                pg_user,
  input  logic                pg_rw,
  input  logic                pg_nx,
  input  logic                pg_present,
  input  logic                pg_rsvd_hit,
  input  logic [1:0]          acc_type,
  input  logic                acc_user,
  input  logic                sup_wp,
  input  logic                exec_guard,
  input  logic                noexec_en,
  input  logic                wide_entry,
  input  logic                key_en,
  input  logic                long_mode,
  input  logic [KEY_W-1:0]    pg_key,
  input  logic [RIGHTS_W-1:0] key_rights,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_allow,
  output logic [PERM_W-1:0]   out_perm,
  output logic [ERR_W-1:0]    out_err
);

  acc_e             acc;
  perm_t            base;
  perm_t            kmask;
  perm_t            fin;
  perm_t            need;
  logic             user_fault;
  logic             key_active;
  logic             key_fault;
  logic             gate_ok;
  logic             c_allow;
  logic [ERR_W-1:0] c_err;

  assign acc = acc_e'(acc_type);

  pgchk_base_perm u_base (
    .pg_user    (pg_user),
    .pg_rw      (pg_rw),
    .pg_nx      (pg_nx),
    .acc_user   (acc_user),
    .sup_wp     (sup_wp),
    .exec_guard (exec_guard),
    .base       (base),
    .user_fault (user_fault)
  );

  pgchk_key_perm #(.KEY_W(KEY_W), .RIGHTS_W(RIGHTS_W)) u_key (
    .key_en     (key_en),
    .long_mode  (long_mode),
    .pg_user    (pg_user),
    .acc_user   (acc_user),
    .sup_wp     (sup_wp),
    .pg_key     (pg_key),
    .key_rights (key_rights),
    .key_active (key_active),
    .mask       (kmask)
  );

  always_comb begin
    need = '0;
    unique case (acc)
      ACC_WRITE: need.write = 1'b1;
      ACC_FETCH: need.exec  = 1'b1;
      default:   need.read  = 1'b1;
    endcase
    gate_ok   = pg_present & ~pg_rsvd_hit & ~user_fault;
    fin       = gate_ok ? (base & kmask) : perm_t'('0);
    key_fault = key_active & ~need.exec & ~(|(kmask & need));
    c_allow   = |(fin & need);
  end

  pgchk_errcode u_err (
    .allow      (c_allow),
    .present    (pg_present),
    .rsvd_hit   (pg_rsvd_hit),
    .user_fault (user_fault),
    .key_fault  (key_fault),
    .acc        (acc),
    .acc_user   (acc_user),
    .noexec_en  (noexec_en),
    .wide_entry (wide_entry),
    .exec_guard (exec_guard),
    .err        (c_err)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic                v_q;
      logic                allow_q;
      logic [PERM_W-1:0]   perm_q;
      logic [ERR_W-1:0]    err_q;
      logic                take;

      assign in_ready = ~v_q | out_ready;
      assign take     = in_valid & in_ready;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q     <= 1'b0;
          allow_q <= 1'b0;
          perm_q  <= '0;
          err_q   <= '0;
        end else begin
          if (in_ready) v_q <= in_valid;
          if (take) begin
            allow_q <= c_allow;
            perm_q  <= fin;
            err_q   <= c_err;
          end
        end
      end

      assign out_valid = v_q;
      assign out_allow = allow_q;
      assign out_perm  = perm_q;
      assign out_err   = c_err_sel(err_q);

      function automatic logic [ERR_W-1:0] c_err_sel(input logic [ERR_W-1:0] e);
        return e;
      endfunction
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_allow = c_allow;
      assign out_perm  = fin;
      assign out_err   = c_err;
    end
  endgenerate

endmodule

// File: rtl/pgchk_sva.sv
module pgchk_sva #(
  parameter int PERM_W = 3,
  parameter int ERR_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_allow,
  input logic [PERM_W-1:0] out_perm,
  input logic [ERR_W-1:0]  out_err
);

  // R12: a stalled result holds every field
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_allow) && $stable(out_perm) && $stable(out_err)));

  // R12: input side is free whenever the output side can move
  assert_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);

  // R11: an allowed access carries no error code and some permission
  assert_allow_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_allow) |-> (out_err == '0 && out_perm != '0));

  // R9: key flag only on a refused protection fault
  assert_key_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err[5]) |-> (out_err[0] && !out_allow && !out_err[3]));

  // R3: reserved flag implies protection bit
  assert_rsvd_prot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err[3]) |-> (out_err[0] && out_perm == '0));

  // R2: not-present refusal leaves no permissions
  assert_np_perm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_allow && !out_err[0]) |-> (out_perm == '0 && !out_err[5]));

endmodule

bind pgchk_top pgchk_sva #(.PERM_W(pgchk_pkg::PERM_W), .ERR_W(pgchk_pkg::ERR_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_allow (out_allow),
  .out_perm  (out_perm),
  .out_err   (out_err)
);

// File: tb/pgchk_top_tb.sv
module pgchk_top_tb;

  localparam int KEY_W    = 4;
  localparam int NKEYS    = 1 << KEY_W;
  localparam int RIGHTS_W = 2 * NKEYS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic in_valid = 0, in_ready, out_valid, out_ready = 0, out_allow;
  logic pg_user = 0, pg_rw = 0, pg_nx = 0, pg_present = 0, pg_rsvd_hit = 0;
  logic [1:0] acc_type = 0;
  logic acc_user = 0, sup_wp = 0, exec_guard = 0, noexec_en = 0, wide_entry = 0;
  logic key_en = 0, long_mode = 0;
  logic [KEY_W-1:0] pg_key = 0;
  logic [RIGHTS_W-1:0] key_rights = 0;
  logic [2:0] out_perm;
  logic [5:0] out_err;

  pgchk_top #(.KEY_W(KEY_W), .RIGHTS_W(RIGHTS_W), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .pg_user(pg_user), .pg_rw(pg_rw), .pg_nx(pg_nx), .pg_present(pg_present),
    .pg_rsvd_hit(pg_rsvd_hit), .acc_type(acc_type), .acc_user(acc_user),
    .sup_wp(sup_wp), .exec_guard(exec_guard), .noexec_en(noexec_en),
    .wide_entry(wide_entry), .key_en(key_en), .long_mode(long_mode),
    .pg_key(pg_key), .key_rights(key_rights), .out_valid(out_valid),
    .out_ready(out_ready), .out_allow(out_allow), .out_perm(out_perm),
    .out_err(out_err)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int stall_pct = 30;

  logic [9:0] exp_q[$];
  string      tag_q[$];
  bit         prev_stall = 0;
  logic [9:0] prev_out;

  // Reference from the requirements: {allow, perm[2:0], err[5:0]}
  function automatic logic [9:0] model();
    logic r, w, x, ka, kr, kw, nr, nw, nx_, allow, uf, kf;
    logic [2:0] perm;
    logic [5:0] e;
    r = 1; w = pg_rw | (!acc_user & !sup_wp);                      // R5
    x = !pg_nx & (acc_user | !(exec_guard & pg_user));             // R6
    ka = key_en & long_mode & pg_user & (key_rights != 0);         // R7
    kr = 1; kw = 1;
    if (ka) begin                                                  // R8
      if (key_rights[2*pg_key]) begin kr = 0; kw = 0; end
      else if (key_rights[2*pg_key+1] && (acc_user || sup_wp)) kw = 0;
    end
    uf = acc_user & !pg_user;                                      // R4
    nr = (acc_type == 2'd0) || (acc_type == 2'd3);                 // R11
    nw = (acc_type == 2'd1);
    nx_ = (acc_type == 2'd2);
    if (!pg_present || pg_rsvd_hit || uf) perm = 3'b000;
    else perm = {x, w & kw, r & kr};
    allow = (nr & perm[0]) | (nw & perm[1]) | (nx_ & perm[2]);
    kf = ka & ((nr & !kr) | (nw & !kw));                           // R9
    e = 0;
    if (!allow) begin                                              // R10
      e[0] = pg_present;
      e[1] = nw;
      e[2] = acc_user;
      e[3] = pg_present & pg_rsvd_hit;
      e[4] = nx_ & ((noexec_en & wide_entry) | exec_guard);
      e[5] = pg_present & !pg_rsvd_hit & !uf & kf;
    end
    return {allow, perm, e};
  endfunction

  task automatic evaluate(output bit took);
    logic [9:0] got;
    took = 0;
    got = {out_allow, out_perm, out_err};
    if (prev_stall) begin
      checks++;
      if (!out_valid || got != prev_out) begin
        errors++;
        $display("FAIL R12 stalled result changed: got %h exp %h", got, prev_out);
      end
    end
    prev_stall = out_valid && !out_ready;
    prev_out = got;
    if (out_valid && out_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R12 unexpected result: got %h exp none", got);
      end else begin
        logic [9:0] ex;
        string tg;
        ex = exp_q.pop_front();
        tg = tag_q.pop_front();
        if (got != ex) begin
          errors++;
          $display("FAIL %s allow/perm/err: got %b_%b_%b exp %b_%b_%b",
                   tg, got[9], got[8:6], got[5:0], ex[9], ex[8:6], ex[5:0]);
        end
      end
    end
    if (in_valid && in_ready) begin
      exp_q.push_back(model());
      tag_q.push_back("");
      took = 1;
    end
  endtask

  task automatic send(input string tag);
    bit took;
    in_valid = 1;
    forever begin
      #5;
      evaluate(took);
      if (took) begin
        tag_q[tag_q.size()-1] = tag;
        break;
      end
      @(negedge clk);
      out_ready = ($urandom_range(99) >= stall_pct);
    end
    @(negedge clk);
    in_valid = 0;
    out_ready = ($urandom_range(99) >= stall_pct);
  endtask

  task automatic setv(input logic p, input logic rv, input logic u, input logic rw,
                      input logic nx, input logic [1:0] a, input logic au,
                      input logic wp, input logic eg);
    pg_present = p; pg_rsvd_hit = rv; pg_user = u; pg_rw = rw; pg_nx = nx;
    acc_type = a; acc_user = au; sup_wp = wp; exec_guard = eg;
    key_en = 0; long_mode = 0; pg_key = 0; key_rights = 0;
    noexec_en = 0; wide_entry = 0;
  endtask

  task automatic keys(input logic [KEY_W-1:0] k, input logic [RIGHTS_W-1:0] rt);
    key_en = 1; long_mode = 1; pg_key = k; key_rights = rt;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: got hang exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit took;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin errors++; $display("FAIL R1 out_valid in reset: got %b exp 0", out_valid); end
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++; $display("FAIL R1 after reset: got v=%b r=%b exp v=0 r=1", out_valid, in_ready);
    end
    out_ready = 1;

    // R2: not present, write and fetch
    setv(0, 0, 1, 1, 0, 2'd1, 1, 0, 0); send("R2");
    setv(0, 1, 0, 0, 0, 2'd2, 0, 1, 1); send("R2");
    // R3: reserved bit on present page
    setv(1, 1, 1, 1, 0, 2'd0, 1, 0, 0); send("R3");
    // R4: user read of supervisor page
    setv(1, 0, 0, 1, 0, 2'd0, 1, 0, 0); send("R4");
    // R5: supervisor write to read-only page, protect off then on
    setv(1, 0, 0, 0, 0, 2'd1, 0, 0, 0); send("R5");
    setv(1, 0, 0, 0, 0, 2'd1, 0, 1, 0); send("R5");
    setv(1, 0, 1, 0, 0, 2'd1, 1, 0, 0); send("R5");
    // R6: no-execute, guarded supervisor fetch, user fetch
    setv(1, 0, 1, 1, 1, 2'd2, 1, 0, 0); send("R6");
    setv(1, 0, 1, 1, 0, 2'd2, 0, 0, 1); send("R6");
    setv(1, 0, 1, 1, 0, 2'd2, 1, 0, 1); send("R6");
    setv(1, 0, 0, 1, 0, 2'd2, 0, 0, 1); send("R6");
    // R7: rights present but gating missing
    setv(1, 0, 1, 1, 0, 2'd0, 1, 0, 0); keys(3, 32'h40); key_en = 0; send("R7");
    setv(1, 0, 1, 1, 0, 2'd0, 1, 0, 0); keys(3, 32'h40); long_mode = 0; send("R7");
    setv(1, 0, 0, 1, 0, 2'd0, 0, 0, 0); keys(3, 32'h40); send("R7");
    setv(1, 0, 1, 1, 0, 2'd1, 1, 0, 0); keys(3, 0); send("R7");
    // R8/R9: access disable, write disable, fetch unaffected, edge keys
    setv(1, 0, 1, 1, 0, 2'd0, 1, 0, 0); keys(5, 32'h400); send("R8 R9");
    setv(1, 0, 1, 1, 0, 2'd1, 1, 0, 0); keys(5, 32'h800); send("R8 R9");
    setv(1, 0, 1, 1, 0, 2'd0, 1, 0, 0); keys(5, 32'h800); send("R8");
    setv(1, 0, 1, 1, 0, 2'd1, 0, 0, 0); keys(5, 32'h800); send("R8");
    setv(1, 0, 1, 1, 0, 2'd1, 0, 1, 0); keys(5, 32'h800); send("R8 R9");
    setv(1, 0, 1, 1, 0, 2'd2, 1, 0, 0); keys(5, 32'h400); send("R8");
    setv(1, 0, 1, 1, 0, 2'd0, 1, 0, 0); keys(0, 32'h1); send("R8 R9");
    setv(1, 0, 1, 1, 0, 2'd1, 1, 0, 0); keys(4'hF, 32'h8000_0000); send("R8 R9");
    setv(1, 0, 1, 1, 0, 2'd0, 1, 0, 0); keys(4'hE, 32'h8000_0000); send("R8");
    setv(1, 0, 1, 0, 0, 2'd1, 1, 0, 0); keys(2, 32'h20); send("R9");
    // R10: fetch bit conditions
    setv(1, 0, 1, 1, 1, 2'd2, 1, 0, 0); noexec_en = 1; wide_entry = 1; send("R10");
    setv(1, 0, 1, 1, 1, 2'd2, 1, 0, 0); noexec_en = 1; send("R10");
    setv(1, 0, 1, 1, 1, 2'd2, 1, 0, 1); send("R10");
    // R11: code 3 behaves as read
    setv(1, 0, 1, 0, 0, 2'd3, 1, 1, 0); send("R11");
    setv(1, 0, 1, 0, 0, 2'd3, 1, 0, 0); keys(1, 32'h4); send("R11");

    // Random mix with stalls, key conditions biased on
    for (int i = 0; i < 600; i++) begin
      pg_present  = ($urandom_range(9) != 0);
      pg_rsvd_hit = ($urandom_range(9) == 0);
      pg_user = ($urandom_range(3) != 0);
      pg_rw = $urandom_range(1); pg_nx = $urandom_range(1);
      acc_type = $urandom_range(3); acc_user = $urandom_range(1);
      sup_wp = $urandom_range(1); exec_guard = $urandom_range(1);
      noexec_en = $urandom_range(1); wide_entry = $urandom_range(1);
      key_en = ($urandom_range(3) != 0); long_mode = ($urandom_range(3) != 0);
      pg_key = $urandom_range(NKEYS - 1);
      key_rights = ($urandom_range(3) == 0) ? '0 : RIGHTS_W'($urandom());
      if ($urandom_range(1)) key_rights[2*pg_key +: 2] = $urandom_range(3);
      send((i % 2) ? "R11" : "R12");
    end

    stall_pct = 0;
    for (int d = 0; d < 20 && exp_q.size() != 0; d++) begin
      out_ready = 1;
      #5; evaluate(took);
      @(negedge clk);
    end
    checks++;
    if (exp_q.size() != 0) begin
      errors++; $display("FAIL R12 results missing: got %0d pending exp 0", exp_q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule